// File: doc/BRIEF.md
# Accumulator CPU Fetch-Execute Controller

This block is a compact accumulator machine. It holds a program counter, an address register, a data register, an opcode register and a 16-bit accumulator. It runs programs out of one synchronous single-port memory. The control unit moves through one register transfer per clock. Every memory access goes through the address and data registers and never straight from the program counter or the accumulator. An instruction word carries a 4-bit opcode in bits 15:12 and a 12-bit operand address in bits 11:0. Three opcodes do work: 0001 adds a memory word to the accumulator, 0010 stores the accumulator, and 0011 jumps. Every other opcode is a no-op.

A level-sensitive interrupt request is sampled once after each instruction. If it is high and interrupts are not masked, the controller writes the program counter to memory word 0. It then continues at address 1 and masks further requests until the next reset. The `run` input gates fetching: the controller only leaves its idle state while `run` is high.

States and transitions: `S_START` goes to `S_F_AR` when run is high and otherwise stays. Fetch is the chain `S_F_AR` (AR←PC) → `S_F_RD` (memory wait) → `S_F_DR` (DR←memory) → `S_F_IR` (IR←opcode, PC←PC+1) → `S_DECODE`. Decode branches as follows: add goes to `S_ADD_AR` → `S_ADD_RD` → `S_ADD_DR` → `S_ADD_AC`; store goes to `S_ST_AR` → `S_ST_DR` → `S_ST_WR`; jump goes to `S_JMP`; a no-op goes straight to `S_IRQ_CHK`. Every execute chain ends in `S_IRQ_CHK`. That state goes to `S_INT_AR` if a request is pending and unmasked, and otherwise to `S_START`. Interrupt entry runs `S_INT_AR` (AR←0) → `S_INT_DR` (DR←PC) → `S_INT_WR` (memory write) → `S_INT_PC` (PC←1, mask set) → `S_START`.

Top module: `acc_cpu`

## Requirements
- R1: After reset, and for as long as `run` is low in the idle state, `mem_we` stays low and `mem_addr` holds its value (0 after reset).
- R2: An instruction is read from the address in the program counter, with one wait cycle between presenting the address and capturing `mem_rdata`. For a store at address 0 executed right after reset, `mem_we` first rises exactly 8 clock edges after `run` rises, and `mem_addr` equals 0 on the 2nd edge.
- R3: Opcode 0001 sets the accumulator to the accumulator plus the memory word at bits 11:0, modulo 2^16.
- R4: Opcode 0010 writes the accumulator to the memory word at bits 11:0, with a `mem_we` strobe one cycle wide.
- R5: Opcode 0011 loads bits 11:0 into the program counter, so the next fetch comes from that address and the words after the jump are skipped.
- R6: Opcodes 0000 and 0100 through 1111 change neither the accumulator nor memory, and execution continues at the next word.
- R7: After an instruction completes with `irq` high and interrupts unmasked, the address of the next instruction is written to memory word 0, and execution continues at address 1.
- R8: After an interrupt entry, further requests are ignored until reset, and reset clears the mask.
- R9: When `run` is dropped, the current instruction finishes and then no more memory writes occur. Raising `run` again resumes execution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables fetching of new instructions |
| irq | input | 1 | Level-sensitive interrupt request |
| mem_addr | output | ADDR_W | Memory address, driven from the address register |
| mem_wdata | output | ADDR_W+4 | Memory write data, driven from the data register |
| mem_rdata | input | ADDR_W+4 | Memory read data, valid one clock after the address |
| mem_we | output | 1 | Memory write strobe |

## Verification
The hardest situation to reach from the ports is an interrupt that arrives while a particular instruction is in flight, because the saved return address depends on when the request is sampled. The bench watches `mem_addr` until it first shows the fetch address of a chosen instruction, and raises `irq` at that moment. This makes the save value deterministic (the following word). The bench then holds `irq` high for hundreds of cycles and counts writes to word 0 to prove the mask holds. It resets and repeats the scenario to show that the mask was cleared. Adder coverage comes from a sweep of 256 operand pairs, including all-ones values, and every unused opcode is swept as a no-op.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OPC_ADD   = 4'b0001;
    localparam logic [OP_W-1:0] OPC_STORE = 4'b0010;
    localparam logic [OP_W-1:0] OPC_JUMP  = 4'b0011;

    typedef enum logic [4:0] {
        S_START,
        S_F_AR,
        S_F_RD,
        S_F_DR,
        S_F_IR,
        S_DECODE,
        S_ADD_AR,
        S_ADD_RD,
        S_ADD_DR,
        S_ADD_AC,
        S_ST_AR,
        S_ST_DR,
        S_ST_WR,
        S_JMP,
        S_IRQ_CHK,
        S_INT_AR,
        S_INT_DR,
        S_INT_WR,
        S_INT_PC
    } cpu_state_e;

    // One-hot style register-transfer strobes issued by the controller
    typedef struct packed {
        logic ar_from_pc;
        logic ar_from_dr;
        logic ar_from_save;
        logic dr_from_mem;
        logic dr_from_ac;
        logic dr_from_pc;
        logic ir_load;
        logic pc_inc;
        logic pc_from_dr;
        logic pc_from_vec;
        logic ac_add;
        logic mask_set;
        logic mem_we;
    } xfer_t;

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                irq,
    input  logic                mask,
    input  logic [OP_W-1:0]     ir,
    output cpu_state_e          state,
    output xfer_t               xfer
);

    cpu_state_e state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_START;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_START:   state_nx = run ? S_F_AR : S_START;
            S_F_AR:    state_nx = S_F_RD;
            S_F_RD:    state_nx = S_F_DR;
            S_F_DR:    state_nx = S_F_IR;
            S_F_IR:    state_nx = S_DECODE;
            S_DECODE: begin
                if      (ir == OPC_ADD)   state_nx = S_ADD_AR;
                else if (ir == OPC_STORE) state_nx = S_ST_AR;
                else if (ir == OPC_JUMP)  state_nx = S_JMP;
                else                      state_nx = S_IRQ_CHK;
            end
            S_ADD_AR:  state_nx = S_ADD_RD;
            S_ADD_RD:  state_nx = S_ADD_DR;
            S_ADD_DR:  state_nx = S_ADD_AC;
            S_ADD_AC:  state_nx = S_IRQ_CHK;
            S_ST_AR:   state_nx = S_ST_DR;
            S_ST_DR:   state_nx = S_ST_WR;
            S_ST_WR:   state_nx = S_IRQ_CHK;
            S_JMP:     state_nx = S_IRQ_CHK;
            S_IRQ_CHK: state_nx = (irq && !mask) ? S_INT_AR : S_START;
            S_INT_AR:  state_nx = S_INT_DR;
            S_INT_DR:  state_nx = S_INT_WR;
            S_INT_WR:  state_nx = S_INT_PC;
            S_INT_PC:  state_nx = S_START;
            default:   state_nx = S_START;
        endcase
    end

    // Output decode: one register transfer per state
    always_comb begin
        xfer = '0;
        unique case (state)
            S_F_AR:   xfer.ar_from_pc   = 1'b1;
            S_F_DR:   xfer.dr_from_mem  = 1'b1;
            S_F_IR: begin
                xfer.ir_load = 1'b1;
                xfer.pc_inc  = 1'b1;
            end
            S_ADD_AR: xfer.ar_from_dr   = 1'b1;
            S_ADD_DR: xfer.dr_from_mem  = 1'b1;
            S_ADD_AC: xfer.ac_add       = 1'b1;
            S_ST_AR:  xfer.ar_from_dr   = 1'b1;
            S_ST_DR:  xfer.dr_from_ac   = 1'b1;
            S_ST_WR:  xfer.mem_we       = 1'b1;
            S_JMP:    xfer.pc_from_dr   = 1'b1;
            S_INT_AR: xfer.ar_from_save = 1'b1;
            S_INT_DR: xfer.dr_from_pc   = 1'b1;
            S_INT_WR: xfer.mem_we       = 1'b1;
            S_INT_PC: begin
                xfer.pc_from_vec = 1'b1;
                xfer.mask_set    = 1'b1;
            end
            default:  xfer = '0;
        endcase
    end

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int SAVE_ADDR = 0,
    parameter int VEC_ADDR  = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  xfer_t                    xfer,
    input  logic [ADDR_W+OP_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]        pc,
    output logic [ADDR_W-1:0]        ar,
    output logic [ADDR_W+OP_W-1:0]   dr,
    output logic [ADDR_W+OP_W-1:0]   ac,
    output logic [OP_W-1:0]          ir,
    output logic                     mask
);

    localparam int DATA_W = ADDR_W + OP_W;
    localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);
    localparam logic [ADDR_W-1:0] VEC_A  = ADDR_W'(VEC_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc   <= '0;
            ar   <= '0;
            dr   <= '0;
            ac   <= '0;
            ir   <= '0;
            mask <= 1'b0;
        end else begin
            if (xfer.ar_from_pc)        ar <= pc;
            else if (xfer.ar_from_dr)   ar <= dr[ADDR_W-1:0];
            else if (xfer.ar_from_save) ar <= SAVE_A;

            if (xfer.dr_from_mem)       dr <= mem_rdata;
            else if (xfer.dr_from_ac)   dr <= ac;
            else if (xfer.dr_from_pc)   dr <= {{OP_W{1'b0}}, pc};

            if (xfer.ir_load)           ir <= dr[DATA_W-1 -: OP_W];

            if (xfer.pc_inc)            pc <= pc + 1'b1;
            else if (xfer.pc_from_dr)   pc <= dr[ADDR_W-1:0];
            else if (xfer.pc_from_vec)  pc <= VEC_A;

            if (xfer.ac_add)            ac <= ac + dr;

            if (xfer.mask_set)          mask <= 1'b1;
        end
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int SAVE_ADDR = 0,
    parameter int VEC_ADDR  = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic                   irq,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [ADDR_W+3:0]      mem_wdata,
    input  logic [ADDR_W+3:0]      mem_rdata,
    output logic                   mem_we
);

    localparam int DATA_W = ADDR_W + OP_W;

    cpu_state_e           state;
    xfer_t                xfer;
    logic [ADDR_W-1:0]    pc;
    logic [ADDR_W-1:0]    ar;
    logic [DATA_W-1:0]    dr;
    logic [DATA_W-1:0]    ac;
    logic [OP_W-1:0]      ir;
    logic                 mask;

    acc_cpu_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .irq   (irq),
        .mask  (mask),
        .ir    (ir),
        .state (state),
        .xfer  (xfer)
    );

    acc_cpu_dp #(
        .ADDR_W    (ADDR_W),
        .SAVE_ADDR (SAVE_ADDR),
        .VEC_ADDR  (VEC_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer      (xfer),
        .mem_rdata (mem_rdata),
        .pc        (pc),
        .ar        (ar),
        .dr        (dr),
        .ac        (ac),
        .ir        (ir),
        .mask      (mask)
    );

    assign mem_addr  = ar;
    assign mem_wdata = dr;
    assign mem_we    = xfer.mem_we;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic                   irq,
    input  logic                   mem_we,
    input  logic [ADDR_W-1:0]      mem_addr,
    input  cpu_state_e             state,
    input  logic [ADDR_W-1:0]      pc,
    input  logic [ADDR_W+3:0]      dr,
    input  logic [ADDR_W+3:0]      ac,
    input  logic [OP_W-1:0]        ir,
    input  logic                   mask
);

    logic is_nop;
    assign is_nop = (ir != OPC_ADD) && (ir != OPC_STORE) && (ir != OPC_JUMP);

    // R1: idle while run is low
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START && !run) |=> (state == S_START && !mem_we));

    // R2: fetch read presents the program counter
    a_r2_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_F_RD) |-> (mem_addr == pc));

    // R3: accumulate
    a_r3_add: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADD_AC) |=> (ac == $past(ac) + $past(dr)));

    // R4: write strobe is a single cycle
    a_r4_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R5: jump target
    a_r5_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_JMP) |=> (pc == $past(dr[ADDR_W-1:0])));

    // R6: no-op leaves accumulator alone
    a_r6_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE && is_nop) |=> (state == S_IRQ_CHK && $stable(ac)));

    // R7: unmasked request enters the handler sequence
    a_r7_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IRQ_CHK && irq && !mask) |=> (state == S_INT_AR));

    // R8: mask is sticky and blocks entry
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mask |=> mask);

    a_r8_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IRQ_CHK && mask) |=> (state == S_START));

endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .irq      (irq),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .state    (state),
    .pc       (pc),
    .dr       (dr),
    .ac       (ac),
    .ir       (ir),
    .mask     (mask)
);

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run;
    logic        irq;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_we;

    always #4 clk = ~clk;

    acc_cpu u_acc_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .irq       (irq),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we)
    );

    logic [15:0] mem [0:255];
    int wr_count    = 0;
    int zero_writes = 0;
    int checks      = 0;
    int fails       = 0;

    // Synchronous single-port memory model
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_count <= wr_count + 1;
            if (mem_addr == 12'h000) zero_writes <= zero_writes + 1;
        end
        mem_rdata <= mem[mem_addr[7:0]];
    end

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        run   = 1'b0;
        irq   = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_for(input int n);
        @(negedge clk);
        run = 1'b1;
        repeat (n) @(negedge clk);
        run = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int base;
        int first;
        logic [15:0] va;
        logic [15:0] vb;

        rst_n = 1'b0;
        run   = 1'b0;
        irq   = 1'b0;
        clear_mem();
        do_reset();

        // R1: idle after reset with run low
        base = wr_count;
        repeat (30) @(negedge clk);
        check("R1 no write while idle", wr_count - base, 0);
        check("R1 mem_we low", mem_we, 0);
        check("R1 addr after reset", mem_addr, 0);

        // R2: cycle timing of a store at address 0
        clear_mem();
        mem[0] = ins(4'b0010, 12'h050);
        mem[1] = ins(4'b0011, 12'h001);
        do_reset();
        first = 0;
        run = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 2) check("R2 fetch address on edge 2", mem_addr, 0);
            if (mem_we && first == 0) begin
                first = k;
                check("R2 store address", mem_addr, 12'h050);
                check("R2 store data", mem_wdata, 0);
            end
        end
        run = 1'b0;
        check("R2 first write edge", first, 8);

        // R3/R4: sweep of operand pairs
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                va = (a == 15) ? 16'hFFFF : 16'(a * 16'h1235);
                vb = (b == 15) ? 16'hFFFF : 16'(b * 16'h2B97);
                clear_mem();
                mem[0]     = ins(4'b0001, 12'h040);
                mem[1]     = ins(4'b0001, 12'h041);
                mem[2]     = ins(4'b0010, 12'h042);
                mem[3]     = ins(4'b0011, 12'h003);
                mem[8'h40] = va;
                mem[8'h41] = vb;
                do_reset();
                base = wr_count;
                run_for(60);
                check("R3 sum", mem[8'h42], 16'(va + vb));
                check("R4 single write", wr_count - base, 1);
            end
        end

        // R5: jump skips words
        clear_mem();
        mem[0]     = ins(4'b0011, 12'h010);
        mem[8'h10] = ins(4'b0001, 12'h040);
        mem[8'h11] = ins(4'b0011, 12'h020);
        mem[8'h12] = ins(4'b0010, 12'h091);
        mem[8'h20] = ins(4'b0010, 12'h092);
        mem[8'h21] = ins(4'b0011, 12'h021);
        mem[8'h40] = 16'h1234;
        mem[8'h91] = 16'hDEAD;
        do_reset();
        base = wr_count;
        run_for(120);
        check("R5 target executed", mem[8'h92], 16'h1234);
        check("R5 skipped word untouched", mem[8'h91], 16'hDEAD);
        check("R5 write count", wr_count - base, 1);

        // R6: every unused opcode is a no-op
        for (int op = 0; op < 16; op++) begin
            if (op >= 1 && op <= 3) continue;
            clear_mem();
            mem[0]     = ins(4'b0001, 12'h040);
            mem[1]     = ins(4'(op), 12'h040);
            mem[2]     = ins(4'b0010, 12'h042);
            mem[3]     = ins(4'b0011, 12'h003);
            mem[8'h40] = 16'h0A5A;
            do_reset();
            base = wr_count;
            run_for(70);
            check("R6 accumulator unchanged", mem[8'h42], 16'h0A5A);
            check("R6 operand untouched", mem[8'h40], 16'h0A5A);
            check("R6 write count", wr_count - base, 1);
        end

        // R7/R8: interrupt entry, mask, and mask cleared by reset
        for (int pass = 0; pass < 2; pass++) begin
            clear_mem();
            mem[0]     = ins(4'b0011, 12'h010);
            mem[1]     = ins(4'b0010, 12'h0A0);
            mem[2]     = ins(4'b0011, 12'h002);
            mem[8'h10] = ins(4'b0001, 12'h040);
            mem[8'h11] = ins(4'b0001, 12'h040);
            mem[8'h12] = ins(4'b0010, 12'h0A1);
            mem[8'h13] = ins(4'b0011, 12'h013);
            mem[8'h40] = 16'h0777;
            mem[8'hA1] = 16'hBEEF;
            do_reset();
            base = zero_writes;
            run = 1'b1;
            for (int g = 0; g < 200; g++) begin
                @(negedge clk);
                if (mem_addr == 12'h010) break;
            end
            irq = 1'b1;
            repeat (400) @(negedge clk);
            run = 1'b0;
            repeat (12) @(negedge clk);
            irq = 1'b0;
            check("R7 saved return address", mem[0], 16'h0011);
            check("R7 handler ran", mem[8'hA0], 16'h0777);
            check("R7 main path left", mem[8'hA1], 16'hBEEF);
            check("R8 single entry", zero_writes - base, 1);
        end

        // R9: dropping run halts, raising it resumes
        clear_mem();
        mem[0] = ins(4'b0010, 12'h090);
        mem[1] = ins(4'b0011, 12'h000);
        do_reset();
        base = wr_count;
        @(negedge clk);
        run = 1'b1;
        repeat (100) @(negedge clk);
        check("R9 writes while running", (wr_count - base) > 0, 1);
        run = 1'b0;
        repeat (30) @(negedge clk);
        base = wr_count;
        repeat (200) @(negedge clk);
        check("R9 no writes after halt", wr_count - base, 0);
        check("R9 strobe low after halt", mem_we, 0);
        run = 1'b1;
        repeat (60) @(negedge clk);
        run = 1'b0;
        check("R9 resumed", (wr_count - base) > 0, 1);
        repeat (20) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule